// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases a contiguous range of erase blocks in a NAND device, from a first index to a last index, one block at a time. For each block it forms the first page row of the block as the block index multiplied by the pages-per-block value. It then drives the erase command sequence onto a byte-wide command/address/data bus, polls the device until it reports ready, and reads a final status byte to decide whether that block erased.

The page class (small or large page), the address-cycle count and the pages-per-block value are inputs. Together they set how many row bytes each erase carries. A block that fails to erase is reported on a per-block result strobe and recorded in a sticky flag, and the range carries on with the next block. A ready wait that runs out of its budget ends the whole range with a timeout error. A range whose last index lies past the block count is refused before any bus activity.

Top module: `nand_erase_seq`

## Requirements
- R1: The row for block b is b multiplied by `pages_per_blk`, and its bytes go out on `bus_out` with `adr_stb` high, least significant byte first.
- R2: With `large_page` low, each erase sends 2 row bytes when `addr_cycles` is 3 or less, 3 when it is 4, and 4 when it is 5 or more.
- R3: With `large_page` high, each erase sends 2 row bytes when `addr_cycles` is 4 or less, and 3 when it is 5 or more.
- R4: Per block the bus order is: command 0x60, the row bytes, command 0xD0, command 0x70, one or more polling reads, command 0x70, and one status read. A command has `cmd_stb` high and the opcode on `bus_out`. A read has `rd_stb` high and samples `bus_in` at that clock edge.
- R5: A polling read with bit 6 of `bus_in` clear is followed, after `unit_cycles` idle cycles (a value of 0 counts as 1), by another polling read. A polling read with bit 6 set ends the wait.
- R6: When WAIT_BUDGET+1 successive polling reads of one block all see bit 6 clear, the block raises `err_timeout` and pulses `done`, drops `busy` in the same cycle, and drives no further bus cycles.
- R7: After each status read, `res_valid` pulses once with `res_blk` set to the block, `res_fail` set to bit 0 of the status byte and `res_status` set to the whole byte. A failed block does not stop the range, and `any_fail` stays high until the next start.
- R8: A start with `last_blk` greater than `num_blocks` raises `err_args` and pulses `done` with no bus cycle. A start with `last_blk` equal to `num_blocks` is accepted.
- R9: After reset, `busy`, `done`, `res_valid`, all three strobes and all error and fail flags are low.
- R10: `busy` is high from the cycle after an accepted start until `done` pulses for one cycle. That pulse comes in the cycle after the last block's status read, and `busy` is low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a range when idle |
| first_blk | input | BLK_W | First block index of the range |
| last_blk | input | BLK_W | Last block index of the range |
| num_blocks | input | BLK_W | Block count of the device, used for argument checking |
| large_page | input | 1 | 1 selects large-page row layout |
| addr_cycles | input | 3 | Address-cycle count of the device |
| pages_per_blk | input | PPB_W | Pages in one erase block |
| unit_cycles | input | UNIT_W | Clock cycles per wait unit |
| bus_in | input | 8 | Byte read from the device |
| cmd_stb | output | 1 | Command byte on bus_out |
| adr_stb | output | 1 | Address byte on bus_out |
| rd_stb | output | 1 | Read of bus_in this cycle |
| bus_out | output | 8 | Command or address byte |
| busy | output | 1 | A range is in progress |
| done | output | 1 | One-cycle end-of-range pulse |
| res_valid | output | 1 | Per-block result strobe |
| res_blk | output | BLK_W | Block index of the result |
| res_fail | output | 1 | Block failed to erase |
| res_status | output | 8 | Final status byte of the block |
| any_fail | output | 1 | Sticky: some block in the range failed |
| err_timeout | output | 1 | Range ended on a ready timeout |
| err_args | output | 1 | Range refused: last index past block count |

## Verification
The bench builds the block with BLK_W=10, PPB_W=9, UNIT_W=8 and WAIT_BUDGET=6. The nine-bit pages-per-block value times block 1023 gives a row above 2^18, so every byte the small-page five-cycle layout sends carries a known value. A budget of six makes the timeout reachable in seven polling reads, and the device model holds ready low for longer than that. A small unit count keeps the spacing between polling reads short enough to measure exactly, including the zero-counts-as-one case.

// File: rtl/nand_erase_pkg.sv
// Shared opcodes and state encoding for the NAND block erase sequencer.
package nand_erase_pkg;
    localparam logic [7:0] OP_ERASE_SETUP   = 8'h60;
    localparam logic [7:0] OP_ERASE_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_READ_STATUS   = 8'h70;
    localparam int         RDY_BIT          = 6;
    localparam int         FAIL_BIT         = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ROW,
        ST_CONF,
        ST_PCMD,
        ST_PRD,
        ST_PWAIT,
        ST_SCMD,
        ST_SRD
    } erase_state_t;
endpackage

// File: rtl/nand_row_sel.sv
// Row byte selector: gives the number of row bytes for the page class and
// address-cycle count, and picks one byte of the row, least significant first.
// Assumes the row fits in 32 bits.
module nand_row_sel (
    input  logic [31:0] row,
    input  logic [1:0]  idx,
    input  logic        large_page,
    input  logic [2:0]  addr_cycles,
    output logic [1:0]  last_idx,
    output logic [7:0]  row_byte
);
    // Row byte count from page class and cycle count, minus one.
    always_comb begin
        if (large_page)
            last_idx = (addr_cycles >= 3'd5) ? 2'd2 : 2'd1;
        else if (addr_cycles >= 3'd5)
            last_idx = 2'd3;
        else if (addr_cycles >= 3'd4)
            last_idx = 2'd2;
        else
            last_idx = 2'd1;
    end

    // Byte lane pick.
    always_comb begin
        row_byte = row[8*idx +: 8];
    end
endmodule

// File: rtl/nand_wait_timer.sv
// Ready-wait timing: a unit countdown between polling reads and a count of
// polling reads against the budget. Assumes load and dec never coincide.
module nand_wait_timer #(
    parameter int UNIT_W      = 16,
    parameter int WAIT_BUDGET = 1000,
    localparam int POLL_W     = $clog2(WAIT_BUDGET + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dec,
    input  logic [UNIT_W-1:0] unit_cycles,
    input  logic              clr_poll,
    input  logic              inc_poll,
    output logic              wait_done,
    output logic              poll_last
);
    logic [UNIT_W-1:0] cnt;
    logic [POLL_W-1:0] polls;

    // Unit countdown; a zero unit is stretched to one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (unit_cycles == '0) ? UNIT_W'(1) : unit_cycles;
        else if (dec && cnt != '0)
            cnt <= cnt - UNIT_W'(1);
    end

    // Polling read counter for the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_poll)
            polls <= '0;
        else if (inc_poll)
            polls <= polls + POLL_W'(1);
    end

    assign wait_done = (cnt <= UNIT_W'(1));
    assign poll_last = (polls == POLL_W'(WAIT_BUDGET));
endmodule

// File: rtl/nand_erase_seq.sv
// NAND block erase sequencer. Walks first_blk..last_blk, issuing per block:
// setup command, row bytes, confirm command, status command, polling reads
// until ready, status command, final status read. Assumes the configuration
// inputs stay stable while busy and that one bus cycle takes one clock.
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int BLK_W       = 12,
    parameter int PPB_W       = 9,
    parameter int UNIT_W      = 16,
    parameter int WAIT_BUDGET = 1000,
    localparam int PROD_W     = BLK_W + PPB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  first_blk,
    input  logic [BLK_W-1:0]  last_blk,
    input  logic [BLK_W-1:0]  num_blocks,
    input  logic              large_page,
    input  logic [2:0]        addr_cycles,
    input  logic [PPB_W-1:0]  pages_per_blk,
    input  logic [UNIT_W-1:0] unit_cycles,
    input  logic [7:0]        bus_in,
    output logic              cmd_stb,
    output logic              adr_stb,
    output logic              rd_stb,
    output logic [7:0]        bus_out,
    output logic              busy,
    output logic              done,
    output logic              res_valid,
    output logic [BLK_W-1:0]  res_blk,
    output logic              res_fail,
    output logic [7:0]        res_status,
    output logic              any_fail,
    output logic              err_timeout,
    output logic              err_args
);
    erase_state_t       state;
    logic [BLK_W-1:0]   blk;
    logic [1:0]         byte_i;
    logic [PROD_W-1:0]  row_full;
    logic [31:0]        row32;
    logic [1:0]         last_idx;
    logic [7:0]         row_byte;
    logic               wait_done;
    logic               poll_last;
    logic               poll_miss;

    // First page row of the current block.
    always_comb begin
        row_full = PROD_W'(blk) * PROD_W'(pages_per_blk);
        row32    = 32'(row_full);
    end

    nand_row_sel u_row (
        .row         (row32),
        .idx         (byte_i),
        .large_page  (large_page),
        .addr_cycles (addr_cycles),
        .last_idx    (last_idx),
        .row_byte    (row_byte)
    );

    assign poll_miss = (state == ST_PRD) && !bus_in[RDY_BIT];

    nand_wait_timer #(
        .UNIT_W      (UNIT_W),
        .WAIT_BUDGET (WAIT_BUDGET)
    ) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (poll_miss && !poll_last),
        .dec         (state == ST_PWAIT),
        .unit_cycles (unit_cycles),
        .clr_poll    (state == ST_PCMD),
        .inc_poll    (poll_miss && !poll_last),
        .wait_done   (wait_done),
        .poll_last   (poll_last)
    );

    // Bus strobes and byte for the current state.
    always_comb begin
        cmd_stb = 1'b0;
        adr_stb = 1'b0;
        rd_stb  = 1'b0;
        bus_out = 8'h00;
        case (state)
            ST_SETUP: begin cmd_stb = 1'b1; bus_out = OP_ERASE_SETUP;   end
            ST_ROW:   begin adr_stb = 1'b1; bus_out = row_byte;         end
            ST_CONF:  begin cmd_stb = 1'b1; bus_out = OP_ERASE_CONFIRM; end
            ST_PCMD,
            ST_SCMD:  begin cmd_stb = 1'b1; bus_out = OP_READ_STATUS;   end
            ST_PRD,
            ST_SRD:   rd_stb = 1'b1;
            default:  ;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // Sequencer state, block walk, results and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            blk         <= '0;
            byte_i      <= '0;
            done        <= 1'b0;
            res_valid   <= 1'b0;
            res_blk     <= '0;
            res_fail    <= 1'b0;
            res_status  <= '0;
            any_fail    <= 1'b0;
            err_timeout <= 1'b0;
            err_args    <= 1'b0;
        end else begin
            done      <= 1'b0;
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    err_args    <= 1'b0;
                    err_timeout <= 1'b0;
                    any_fail    <= 1'b0;
                    if (last_blk > num_blocks) begin
                        err_args <= 1'b1;
                        done     <= 1'b1;
                    end else if (first_blk > last_blk) begin
                        done <= 1'b1;
                    end else begin
                        blk   <= first_blk;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    byte_i <= '0;
                    state  <= ST_ROW;
                end
                ST_ROW: begin
                    if (byte_i == last_idx)
                        state <= ST_CONF;
                    else
                        byte_i <= byte_i + 2'd1;
                end
                ST_CONF:  state <= ST_PCMD;
                ST_PCMD:  state <= ST_PRD;
                ST_PRD: begin
                    if (bus_in[RDY_BIT])
                        state <= ST_SCMD;
                    else if (poll_last) begin
                        err_timeout <= 1'b1;
                        done        <= 1'b1;
                        state       <= ST_IDLE;
                    end else
                        state <= ST_PWAIT;
                end
                ST_PWAIT: if (wait_done) state <= ST_PRD;
                ST_SCMD:  state <= ST_SRD;
                ST_SRD: begin
                    res_valid  <= 1'b1;
                    res_blk    <= blk;
                    res_fail   <= bus_in[FAIL_BIT];
                    res_status <= bus_in;
                    if (bus_in[FAIL_BIT])
                        any_fail <= 1'b1;
                    if (blk == last_blk) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        blk   <= blk + BLK_W'(1);
                        state <= ST_SETUP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_erase_seq_chk.sv
// Property checker for the erase sequencer, bound to every instance.
module nand_erase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cmd_stb,
    input logic       adr_stb,
    input logic       rd_stb,
    input logic [7:0] bus_out,
    input logic       res_valid,
    input logic       err_timeout,
    input logic       err_args
);
    // R4: at most one kind of bus cycle at a time
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, adr_stb, rd_stb}));

    // R4: the confirm command is followed at once by a status command
    p_confirm_then_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && bus_out == 8'hD0) |=> (cmd_stb && bus_out == 8'h70));

    // R6: a timeout ends the range with done and busy low
    p_timeout_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (done && !busy));

    // R7: each result follows a read of the device
    p_result_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rd_stb));

    // R8: a refused range produces done without ever going busy
    p_args_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_args) |-> (done && !busy && !$past(busy)));

    // R10: done is a single-cycle pulse with busy low
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R9: no bus cycles while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(cmd_stb || adr_stb || rd_stb));
endmodule

bind nand_erase_seq nand_erase_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .cmd_stb     (cmd_stb),
    .adr_stb     (adr_stb),
    .rd_stb      (rd_stb),
    .bus_out     (bus_out),
    .res_valid   (res_valid),
    .err_timeout (err_timeout),
    .err_args    (err_args)
);

// File: tb/tb_nand_erase_seq.sv
module tb_nand_erase_seq;
    localparam int BLK_W  = 10;
    localparam int PPB_W  = 9;
    localparam int UNIT_W = 8;
    localparam int BUDGET = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [BLK_W-1:0]  first_blk = '0, last_blk = '0, num_blocks = '0;
    logic              large_page = 1'b0;
    logic [2:0]        addr_cycles = 3'd3;
    logic [PPB_W-1:0]  pages_per_blk = '0;
    logic [UNIT_W-1:0] unit_cycles = '0;
    logic [7:0]        bus_in;
    logic              cmd_stb, adr_stb, rd_stb, busy, done, res_valid;
    logic              res_fail, any_fail, err_timeout, err_args;
    logic [7:0]        bus_out, res_status;
    logic [BLK_W-1:0]  res_blk;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    nand_erase_seq #(.BLK_W(BLK_W), .PPB_W(PPB_W), .UNIT_W(UNIT_W),
                     .WAIT_BUDGET(BUDGET)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk),
        .last_blk(last_blk), .num_blocks(num_blocks), .large_page(large_page),
        .addr_cycles(addr_cycles), .pages_per_blk(pages_per_blk),
        .unit_cycles(unit_cycles), .bus_in(bus_in), .cmd_stb(cmd_stb),
        .adr_stb(adr_stb), .rd_stb(rd_stb), .bus_out(bus_out), .busy(busy),
        .done(done), .res_valid(res_valid), .res_blk(res_blk),
        .res_fail(res_fail), .res_status(res_status), .any_fail(any_fail),
        .err_timeout(err_timeout), .err_args(err_args));

    // Device model: ready after busy_n polling reads, status bit 0 from mask.
    int          busy_n = 0;
    logic [15:0] fail_mask = '0;
    int          rcnt = 0, ord = 0;
    logic        fail_now;
    assign fail_now = (ord == 0) ? 1'b0 : fail_mask[ord-1];
    assign bus_in = (rcnt >= busy_n) ? {1'b0, 1'b1, 5'b0, fail_now} : 8'h00;

    // Bus log: kind 0 command, 1 address, 2 read.
    int lk [0:1023];
    int lb [0:1023];
    int lc [0:1023];
    int nlog = 0;
    int rb [0:63];
    int rf [0:63];
    int nres = 0;
    int done_cnt = 0;
    int busy_at_done = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (start && !busy) begin
            nlog = 0; nres = 0; done_cnt = 0;
            ord  <= 0; rcnt <= 0;
        end
        if ((cmd_stb || adr_stb || rd_stb) && nlog < 1024) begin
            lk[nlog] = cmd_stb ? 0 : (adr_stb ? 1 : 2);
            lb[nlog] = rd_stb ? 0 : int'(bus_out);
            lc[nlog] = cyc;
            nlog = nlog + 1;
        end
        if (cmd_stb && bus_out == 8'hD0) begin
            rcnt <= 0; ord <= ord + 1;
        end else if (rd_stb) rcnt <= rcnt + 1;
        if (res_valid && nres < 64) begin
            rb[nres] = int'(res_blk); rf[nres] = int'(res_fail); nres = nres + 1;
        end
        if (done) begin done_cnt = done_cnt + 1; busy_at_done = int'(busy); end
    end

    // Expected log
    int ek [0:1023];
    int eb [0:1023];
    int ne = 0;

    task automatic push(input int k, input int b);
        ek[ne] = k; eb[ne] = b; ne = ne + 1;
    endtask

    function automatic int row_bytes(input bit lg, input int ac);
        if (lg) return (ac >= 5) ? 3 : 2;
        if (ac >= 5) return 4;
        if (ac >= 4) return 3;
        return 2;
    endfunction

    task automatic build(input int f, input int l, input bit lg, input int ac,
                         input int ppb, input int bsy, input bit to);
        ne = 0;
        for (int b = f; b <= l; b++) begin
            int row = b * ppb;
            push(0, 8'h60);
            for (int i = 0; i < row_bytes(lg, ac); i++) push(1, (row >> (8*i)) & 8'hFF);
            push(0, 8'hD0);
            push(0, 8'h70);
            if (to) begin
                for (int i = 0; i <= BUDGET; i++) push(2, 0);
                return;
            end
            for (int i = 0; i <= bsy; i++) push(2, 0);
            push(0, 8'h70);
            push(2, 0);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        for (int i = 0; i < ne && i < nlog; i++)
            if (bad < 0 && (lk[i] != ek[i] || lb[i] != eb[i])) bad = i;
        if (nlog != ne) chk(0, {tag, " log length"}, nlog, ne);
        else if (bad >= 0) chk(0, {tag, " log entry byte"}, lb[bad], eb[bad]);
        else chk(1, tag, 0, 0);
    endtask

    task automatic run(input int f, input int l, input int num, input bit lg,
                       input int ac, input int ppb, input int unit, input int bsy,
                       input logic [15:0] mask);
        @(negedge clk);
        first_blk = BLK_W'(f); last_blk = BLK_W'(l); num_blocks = BLK_W'(num);
        large_page = lg; addr_cycles = 3'(ac); pages_per_blk = PPB_W'(ppb);
        unit_cycles = UNIT_W'(unit); busy_n = bsy; fail_mask = mask;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // Gap in cycles between the first two polling reads.
    function automatic int poll_gap();
        for (int i = 0; i + 1 < nlog; i++)
            if (lk[i] == 2 && lk[i+1] == 2) return lc[i+1] - lc[i];
        return -1;
    endfunction

    task automatic t_reset();
        chk(!busy && !done && !res_valid && !cmd_stb && !adr_stb && !rd_stb &&
            !any_fail && !err_timeout && !err_args, "R9 reset state", int'(busy), 0);
    endtask

    task automatic t_small3();
        run(2, 4, 100, 0, 3, 32, 2, 1, 16'h0);
        build(2, 4, 0, 3, 32, 1, 0);
        cmp_log("R1 R2 R4 small page 3 cycles");
        chk(nres == 3 && rb[0] == 2 && rb[2] == 4 && rf[0] == 0 && rf[1] == 0 && rf[2] == 0,
            "R7 results pass", nres, 3);
        chk(done_cnt == 1 && busy_at_done == 0 && !any_fail, "R10 single done", done_cnt, 1);
        chk(poll_gap() == 3, "R5 poll spacing unit 2", poll_gap(), 3);
    endtask

    task automatic t_small4();
        run(300, 301, 1000, 0, 4, 32, 0, 1, 16'h0);
        build(300, 301, 0, 4, 32, 1, 0);
        cmp_log("R2 small page 4 cycles");
        chk(poll_gap() == 2, "R5 unit zero counts as one", poll_gap(), 2);
    endtask

    task automatic t_small5();
        run(1023, 1023, 1023, 0, 5, 511, 3, 0, 16'h0);
        build(1023, 1023, 0, 5, 511, 0, 0);
        cmp_log("R1 R2 R8 small page 5 cycles, last equals count");
        chk(!err_args && nres == 1, "R8 boundary accepted", int'(err_args), 0);
    endtask

    task automatic t_large();
        run(1023, 1023, 1023, 1, 4, 64, 1, 2, 16'h0);
        build(1023, 1023, 1, 4, 64, 2, 0);
        cmp_log("R3 large page 4 cycles");
        run(7, 8, 1023, 1, 5, 64, 1, 0, 16'h0);
        build(7, 8, 1, 5, 64, 0, 0);
        cmp_log("R3 large page 5 cycles");
    endtask

    task automatic t_fail();
        run(5, 7, 50, 0, 3, 16, 1, 0, 16'h0002);
        build(5, 7, 0, 3, 16, 0, 0);
        cmp_log("R7 range continues after failure");
        chk(nres == 3 && rf[0] == 0 && rf[1] == 1 && rf[2] == 0 && rb[1] == 6,
            "R7 per-block fail flags", rf[1], 1);
        chk(any_fail == 1'b1, "R7 sticky fail", int'(any_fail), 1);
        chk(res_status == 8'h40, "R7 last status byte", int'(res_status), 8'h40);
    endtask

    task automatic t_timeout();
        run(3, 6, 50, 0, 3, 8, 1, 100, 16'h0);
        build(3, 6, 0, 3, 8, 0, 1);
        cmp_log("R6 timeout stops bus");
        chk(err_timeout && nres == 0 && done_cnt == 1 && busy_at_done == 0,
            "R6 timeout flag and done", int'(err_timeout), 1);
        run(3, 3, 50, 0, 3, 8, 1, 0, 16'h0);
        chk(!err_timeout && nres == 1, "R6 flag cleared by next start", int'(err_timeout), 0);
    endtask

    task automatic t_args();
        run(0, 51, 50, 0, 3, 8, 1, 0, 16'h0);
        chk(err_args && nlog == 0 && done_cnt == 1, "R8 invalid range refused", nlog, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_small3();
        t_small4();
        t_small5();
        t_large();
        t_fail();
        t_timeout();
        t_args();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule